// File: doc/BRIEF.md
# Four-Stage Shift/Load Register with Two-Input Serial Entry

This block is a small clocked register of four stages. On each rising clock edge it does one of two things, picked by a mode input. In shift mode, every stage hands its value to the next higher stage. Stage 0 takes a fresh bit from a pair of serial control inputs. In load mode, all four stages capture a four-bit data word, one bit per stage.

The serial pair is a J input and a K input that is active low. Together they can set, clear, invert or keep stage 0. Tying the two inputs to the same signal turns the pair into an ordinary serial data input.

An active-low master reset clears all stages at once, without waiting for the clock. Besides the four stage values, the block drives the inverse of the last stage. A shift toward stage 0 needs no mode of its own. The surrounding logic feeds each stage output back to the data input one position lower and keeps the block in load mode.

Top module: `pa_shift_reg`

## Requirements
- R1: With `shift_en` = 1, a rising edge moves `q[i-1]` into `q[i]` for i = 1 to 3.
- R2: With `shift_en` = 0, a rising edge loads `par_d[i]` into `q[i]` for every i, and `j_in`/`kn_in` have no effect.
- R3: In shift mode with `j_in` = 1 and `kn_in` = 1, the new `q[0]` is 1.
- R4: In shift mode with `j_in` = 0 and `kn_in` = 0, the new `q[0]` is 0.
- R5: In shift mode with `j_in` = 1 and `kn_in` = 0, the new `q[0]` is the inverse of the old `q[0]`.
- R6: In shift mode with `j_in` = 0 and `kn_in` = 1, `q[0]` keeps its old value.
- R7: While `rst_n` = 0, `q` is 0000 at once, without a clock edge, whatever the other inputs are. This holds even across a rising edge.
- R8: `q_last_n` is always the inverse of `q[3]`, so it is 1 during reset.
- R9: The first rising edge after `rst_n` returns to 1 acts normally on the inputs sampled at that edge.
- R10: In load mode, driving `par_d[i-1]` from `q[i]` shifts the word one place toward stage 0, with `par_d[3]` as the new top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change except reset happens on its rising edge |
| rst_n | input | 1 | Asynchronous master reset, active low |
| shift_en | input | 1 | 1 selects shift mode, 0 selects parallel load |
| j_in | input | 1 | Serial entry input J for stage 0 |
| kn_in | input | 1 | Serial entry input K for stage 0, active low |
| par_d | input | 4 | Parallel load word; bit i goes to stage i |
| q | output | 4 | Stage values; bit i is stage i |
| q_last_n | output | 1 | Inverse of stage 3 |

## Verification
The master reset and a clock edge can meet in the same cycle. The bench provokes this in two ways. First, a reset pulse starts and ends in the low half of a clock cycle while a load or shift is already set up. Second, reset stays low across a rising edge while load inputs ask for all ones. The scoreboard expects zeros at the moment reset falls and across a held edge. After a pulse it expects the next edge to act on its own inputs, starting from a cleared register. It also checks the inverted last-stage output at every one of these points.

// File: rtl/psr_pkg.sv
`timescale 1ns/1ps
package psr_pkg;

    // Encoding is {j_in, kn_in}; kn_in is the active-low K input.
    typedef enum logic [1:0] {
        ENTRY_CLEAR  = 2'b00,
        ENTRY_HOLD   = 2'b01,
        ENTRY_TOGGLE = 2'b10,
        ENTRY_SET    = 2'b11
    } entry_op_e;

    function automatic logic entry_next(entry_op_e op, logic cur);
        logic r;
        unique case (op)
            ENTRY_CLEAR:  r = 1'b0;
            ENTRY_HOLD:   r = cur;
            ENTRY_TOGGLE: r = ~cur;
            default:      r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/psr_entry_stage.sv
`timescale 1ns/1ps
module psr_entry_stage
    import psr_pkg::*;
(
    input  logic      j_in,
    input  logic      kn_in,
    input  logic      cur_bit,
    output entry_op_e op,
    output logic      nxt_bit
);

    always_comb begin
        op      = entry_op_e'({j_in, kn_in});
        nxt_bit = entry_next(op, cur_bit);
    end

endmodule

// File: rtl/psr_stage_mux.sv
`timescale 1ns/1ps
module psr_stage_mux #(
    parameter int STAGES = 4
) (
    input  logic              shift_en,
    input  logic              entry_bit,
    input  logic [STAGES-1:0] cur,
    input  logic [STAGES-1:0] par_d,
    output logic [STAGES-1:0] nxt
);

    localparam int LAST = STAGES - 1;

    always_comb begin
        nxt[0] = shift_en ? entry_bit : par_d[0];
    end

    for (genvar i = 1; i <= LAST; i++) begin : g_stage
        always_comb begin
            nxt[i] = shift_en ? cur[i-1] : par_d[i];
        end
    end

endmodule

// File: rtl/pa_shift_reg.sv
`timescale 1ns/1ps
module pa_shift_reg
    import psr_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              j_in,
    input  logic              kn_in,
    input  logic [STAGES-1:0] par_d,
    output logic [STAGES-1:0] q,
    output logic              q_last_n
);

    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] stage;
    } state_t;

    state_t            state_d;
    state_t            state_q;
    entry_op_e         entry_op;
    logic              entry_bit;
    logic [STAGES-1:0] mux_nxt;

    psr_entry_stage u_entry (
        .j_in    (j_in),
        .kn_in   (kn_in),
        .cur_bit (state_q.stage[0]),
        .op      (entry_op),
        .nxt_bit (entry_bit)
    );

    psr_stage_mux #(.STAGES(STAGES)) u_mux (
        .shift_en  (shift_en),
        .entry_bit (entry_bit),
        .cur       (state_q.stage),
        .par_d     (par_d),
        .nxt       (mux_nxt)
    );

    always_comb begin
        state_d       = state_q;
        state_d.stage = mux_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign q        = state_q.stage;
    assign q_last_n = ~state_q.stage[LAST];

    // Checker state: high only when the last edge was a normal update and
    // no reset has occurred since it.
    logic check_armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) check_armed_q <= 1'b0;
        else        check_armed_q <= 1'b1;
    end

    assert_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
        check_armed_q && $past(shift_en) |-> q[LAST:1] == $past(q[LAST-1:0]));

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        check_armed_q && !$past(shift_en) |-> q == $past(par_d));

    assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        check_armed_q && $past(shift_en && j_in && kn_in) |-> q[0]);

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        check_armed_q && $past(shift_en && !j_in && !kn_in) |-> !q[0]);

    assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        check_armed_q && $past(shift_en && j_in && !kn_in) |-> q[0] != $past(q[0]));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        check_armed_q && $past(shift_en && !j_in && kn_in) |-> q[0] == $past(q[0]));

    assert_reset_R7: assert property (@(posedge clk)
        !rst_n |-> (q == '0) && q_last_n);

endmodule

// File: tb/pa_shift_reg_tb.sv
`timescale 1ns/1ps
module pa_shift_reg_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shift_en = 1'b0;
    logic       j_in = 1'b0;
    logic       kn_in = 1'b0;
    logic [3:0] par_d = 4'h0;
    logic [3:0] q;
    logic       q_last_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [3:0] model_q = 4'h0;
    logic [3:0] exp_fifo[$];
    string      tag_fifo[$];

    always #2 clk = ~clk;

    pa_shift_reg u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .j_in     (j_in),
        .kn_in    (kn_in),
        .par_d    (par_d),
        .q        (q),
        .q_last_n (q_last_n)
    );

    function automatic logic [3:0] model_next(logic [3:0] m, logic se, logic j,
                                              logic kn, logic [3:0] d);
        logic first;
        if (!se) return d;
        case ({j, kn})
            2'b00:   first = 1'b0;
            2'b01:   first = m[0];
            2'b10:   first = ~m[0];
            default: first = 1'b1;
        endcase
        return {m[2:0], first};
    endfunction

    function automatic string tag_of(logic se, logic j, logic kn);
        if (!se) return "R2";
        case ({j, kn})
            2'b00:   return "R1 R4";
            2'b01:   return "R1 R6";
            2'b10:   return "R1 R5";
            default: return "R1 R3";
        endcase
    endfunction

    task automatic check_now(string tag, logic [3:0] exp);
        checks++;
        if (q !== exp || q_last_n !== ~exp[3]) begin
            errors++;
            $display("FAIL %s (R8 on q_last_n): q=%b q_last_n=%b expected q=%b q_last_n=%b",
                     tag, q, q_last_n, exp, ~exp[3]);
        end
    endtask

    // Driver: called at a negedge, returns at the next negedge.
    task automatic step(logic se, logic j, logic kn, logic [3:0] d, string tag);
        shift_en = se; j_in = j; kn_in = kn; par_d = d;
        model_q = model_next(model_q, se, j, kn, d);
        exp_fifo.push_back(model_q);
        tag_fifo.push_back(tag);
        @(negedge clk);
    endtask

    // Reset pulse inside the low clock phase; next edge acts from zero (R9).
    task automatic mid_reset(logic se, logic j, logic kn, logic [3:0] d);
        shift_en = se; j_in = j; kn_in = kn; par_d = d;
        model_q = model_next(4'h0, se, j, kn, d);
        exp_fifo.push_back(model_q);
        tag_fifo.push_back("R9");
        #0.5 rst_n = 1'b0;
        #0.3 check_now("R7 mid-cycle", 4'h0);
        #0.5 rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Reset held low across a rising edge with a load requested.
    task automatic held_reset();
        rst_n = 1'b0;
        shift_en = 1'b0; j_in = 1'b1; kn_in = 1'b1; par_d = 4'hF;
        #0.5 check_now("R7 immediate", 4'h0);
        model_q = 4'h0;
        exp_fifo.push_back(4'h0);
        tag_fifo.push_back("R7 across edge");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_fifo.size() != 0) begin
                logic [3:0] e;
                string t;
                e = exp_fifo.pop_front();
                t = tag_fifo.pop_front();
                check_now(t, e);
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        #1 check_now("R7 R8 reset state", 4'h0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        step(1'b0, 1'b1, 1'b0, 4'b1010, "R2 jk ignored");
        step(1'b1, 1'b1, 1'b1, 4'b0000, "R1 R3");
        step(1'b1, 1'b0, 1'b0, 4'b1111, "R1 R4");
        step(1'b1, 1'b1, 1'b0, 4'b0000, "R1 R5");
        step(1'b1, 1'b1, 1'b0, 4'b0000, "R1 R5");
        step(1'b1, 1'b0, 1'b1, 4'b0000, "R1 R6");
        step(1'b1, 1'b1, 1'b0, 4'b0000, "R1 R5");
        step(1'b1, 1'b0, 1'b1, 4'b0000, "R1 R6");
        step(1'b0, 1'b0, 1'b0, 4'b0110, "R2 jk ignored");
        step(1'b0, 1'b1, 1'b1, 4'b1001, "R2 jk ignored");

        // Left shift by feeding q[i] back into par_d[i-1]
        for (int n = 0; n < 4; n++) begin
            step(1'b0, 1'b0, 1'b1, {n[0], model_q[3:1]}, "R10");
        end

        mid_reset(1'b0, 1'b0, 1'b0, 4'b1101);
        step(1'b1, 1'b1, 1'b1, 4'b0000, "R1 R3");
        mid_reset(1'b1, 1'b1, 1'b1, 4'b0000);
        held_reset();
        step(1'b1, 1'b1, 1'b1, 4'b0000, "R9 R3");

        lfsr = 8'hA5;
        for (int n = 0; n < 60; n++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr[0] | lfsr[6], lfsr[1], lfsr[2], lfsr[7:4],
                 tag_of(lfsr[0] | lfsr[6], lfsr[1], lfsr[2]));
        end
        mid_reset(1'b1, 1'b1, 1'b0, 4'b0000);

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule